// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Loop

This unit takes a byte, word or long operand, a 6-bit count and an operation code. It returns the shifted or rotated result and the next X, N, Z, V and C condition flags. Eight operations are available: arithmetic, logical and plain rotate, each to the left and to the right, plus rotate through extend in both directions. In rotate through extend the X flag becomes one more bit of the circulating loop. The whole count is resolved in one combinational pass, whatever its value.

The result is combinational. The flags are held in a register that loads on the `upd_valid` strobe, so a pipeline can present an operation and commit its flags in the same cycle. The unit accepts every strobe and never applies back-pressure, so there is no ready signal. With the strobe low, the flag register keeps its value while the result still follows the inputs. When the operation works on a byte or a word, the operand bits above the selected size pass through to `res` unchanged.

Top module: `srx_unit`

## Requirements
- R1: Operation code encoding is ASR=0, ASL=1, LSR=2, LSL=3, ROXR=4, ROXL=5, ROR=6, ROL=7. For LSL and LSR the result is the operand shifted with zero fill, and a count of at least the size width gives zero. For a nonzero count, C is the last bit shifted out: bit (w-count) for left and bit (count-1) for right. C is 0 when count exceeds w.
- R2: ASR fills with the sign bit, and a count of at least w gives all sign bits. For a nonzero count, C is bit (count-1), or the sign bit when count exceeds w.
- R3: ASL gives the same result and C as LSL. It sets V when the most significant bit takes more than one value at any point during the shift, including zeros that enter it. Every other operation clears V.
- R4: With a zero count, ASL, ASR, LSL and LSR return the operand unchanged, clear C and V, and set X to the current X.
- R5: ROL and ROR rotate within the size width, using count modulo w. C is the last bit rotated out for a nonzero count and 0 for a zero count. X always equals the current X.
- R6: ROXL and ROXR rotate the (w+1)-bit loop formed by X above the operand, using count modulo (w+1). The new X is the loop's top bit after the rotation, and C equals the new X. With a zero count, both X and C equal the current X.
- R7: For the four shifts with a nonzero count, the next X equals the next C.
- R8: N is the top bit of the sized result and Z is set when the sized result is all zeros. Operand bits above the selected size appear unchanged on `res`.
- R9: Reset clears all five flags. The flags load only in a cycle where `upd_valid` is high at the rising clock edge, and they hold otherwise.
- R10: Size encoding is 0=byte (8 bits), 1=word (16 bits), 2=long (32 bits). Code 3 behaves as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | Strobe: load next flags at this edge |
| opnd | input | 32 | Operand (low bits used per size) |
| amount | input | 6 | Shift or rotate count, 0 to 63 |
| size_sel | input | 2 | Operand size code |
| op_sel | input | 3 | Operation code |
| x_cur | input | 1 | Current X flag |
| res | output | 32 | Result with upper bits passed through |
| flg_x | output | 1 | Registered X flag |
| flg_n | output | 1 | Registered N flag |
| flg_z | output | 1 | Registered Z flag |
| flg_v | output | 1 | Registered V flag |
| flg_c | output | 1 | Registered C flag |

## Verification
Two rules can meet in one cycle. With a count of zero, the X-preserving rule for shifts (or the rule that C takes X for rotate through extend) lands in the same flag load as the N and Z update. With an ASL count of at least the width, the overflow rule and the carry rule meet, giving V set together with C=0 for a count above w, or C equal to bit 0 for a count of exactly w. The bench sweeps every operation, every size, every count from 0 to 63 and both X values over operands chosen so that sign bits and zero results vary. Each flag load is judged against a bench model that shifts one bit at a time. Separate strobe-low cycles confirm that the registered flags hold.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int NUM_SIZES = 3;
  localparam int BASE_W    = 8;

  typedef enum logic [2:0] {
    OP_ASR  = 3'd0,
    OP_ASL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_LSL  = 3'd3,
    OP_ROXR = 3'd4,
    OP_ROXL = 3'd5,
    OP_ROR  = 3'd6,
    OP_ROL  = 3'd7
  } shop_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Width of the size with index idx: 8, 16, 32 ...
  function automatic int size_bits(input int idx);
    return BASE_W << idx;
  endfunction

  // Size code to index; codes past the last size use the widest
  function automatic int size_index(input logic [1:0] code);
    if (int'(code) < NUM_SIZES) return int'(code);
    return NUM_SIZES - 1;
  endfunction

endpackage

// File: rtl/srx_core.sv
module srx_core
  import srx_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     a,
  input  logic [CNT_W-1:0] cnt,
  input  shop_e            op,
  input  logic             x_in,
  output logic [W-1:0]     res,
  output logic             c_out,
  output logic             x_out,
  output logic             v_out
);

  localparam int KW = $clog2(W);
  localparam int LW = W + 1;

  logic             nz;
  logic             wide;
  logic [CNT_W-1:0] cm1;
  logic [KW-1:0]    k;
  logic [CNT_W-1:0] kx;
  logic [W-1:0]     shl, shr, sar;
  logic [W-1:0]     shl_p, shr_p, sar_p;
  logic [W-1:0]     rol, ror;
  logic [W-1:0]     top_m, top_b;
  logic             asl_v;
  logic [LW-1:0]    loop_v, loop_l, loop_r;

  // Count decode
  always_comb begin
    nz   = |cnt;
    wide = int'(cnt) >= W;
    cm1  = cnt - CNT_W'(1);
    k    = cnt[KW-1:0];
    kx   = CNT_W'(int'(cnt) % LW);
  end

  // Barrel shifts; the one-short versions expose the last bit out
  always_comb begin
    shl   = a << cnt;
    shr   = a >> cnt;
    sar   = W'($signed(a) >>> cnt);
    shl_p = a << cm1;
    shr_p = a >> cm1;
    sar_p = W'($signed(a) >>> cm1);
  end

  // Plain rotates inside the size width
  always_comb begin
    rol = (a << k) | (a >> (W - int'(k)));
    ror = (a >> k) | (a << (W - int'(k)));
  end

  // Extend loop: X sits above the operand
  always_comb begin
    loop_v = {x_in, a};
    loop_l = (loop_v << kx) | (loop_v >> (LW - int'(kx)));
    loop_r = (loop_v >> kx) | (loop_v << (LW - int'(kx)));
  end

  // Overflow for left arithmetic: the top cnt+1 bits must agree,
  // and once the count reaches W a zero reaches the sign position
  always_comb begin
    top_m = ~({W{1'b1}} >> (int'(cnt) + 1));
    top_b = a & top_m;
    if (!nz)
      asl_v = 1'b0;
    else if (wide)
      asl_v = |a;
    else
      asl_v = (|top_b) && (top_b != top_m);
  end

  always_comb begin
    res   = a;
    c_out = 1'b0;
    x_out = x_in;
    v_out = 1'b0;
    unique case (op)
      OP_ASL, OP_LSL: begin
        res = shl;
        if (nz) begin
          c_out = shl_p[W-1];
          x_out = shl_p[W-1];
        end
        if (op == OP_ASL) v_out = asl_v;
      end
      OP_LSR: begin
        res = shr;
        if (nz) begin
          c_out = shr_p[0];
          x_out = shr_p[0];
        end
      end
      OP_ASR: begin
        res = sar;
        if (nz) begin
          c_out = sar_p[0];
          x_out = sar_p[0];
        end
      end
      OP_ROL: begin
        res = rol;
        if (nz) c_out = rol[0];
      end
      OP_ROR: begin
        res = ror;
        if (nz) c_out = ror[W-1];
      end
      OP_ROXL: begin
        res   = loop_l[W-1:0];
        x_out = loop_l[W];
        c_out = loop_l[W];
      end
      OP_ROXR: begin
        res   = loop_r[W-1:0];
        x_out = loop_r[W];
        c_out = loop_r[W];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/srx_flag_reg.sv
module srx_flag_reg
  import srx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ccr_t d,
  output ccr_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q == $past(q)); // R9

endmodule

// File: rtl/srx_unit.sv
module srx_unit
  import srx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  upd_valid,
  input  logic [size_bits(NUM_SIZES-1)-1:0]     opnd,
  input  logic [CNT_W-1:0]                      amount,
  input  logic [1:0]                            size_sel,
  input  logic [2:0]                            op_sel,
  input  logic                                  x_cur,
  output logic [size_bits(NUM_SIZES-1)-1:0]     res,
  output logic                                  flg_x,
  output logic                                  flg_n,
  output logic                                  flg_z,
  output logic                                  flg_v,
  output logic                                  flg_c
);

  localparam int DW = size_bits(NUM_SIZES - 1);

  logic [DW-1:0]        res_arr [NUM_SIZES];
  logic [NUM_SIZES-1:0] c_arr, x_arr, v_arr, n_arr, z_arr;
  int                   sidx;
  ccr_t                 nxt, cur;
  shop_e                op_t;

  assign op_t = shop_e'(op_sel);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int          W    = size_bits(g);
    localparam logic [DW-1:0] LOWM = (DW'(1) << W) - DW'(1);
    logic [W-1:0] r;

    srx_core #(.W(W), .CNT_W(CNT_W)) u_core (
      .a     (opnd[W-1:0]),
      .cnt   (amount),
      .op    (op_t),
      .x_in  (x_cur),
      .res   (r),
      .c_out (c_arr[g]),
      .x_out (x_arr[g]),
      .v_out (v_arr[g])
    );

    assign res_arr[g] = (opnd & ~LOWM) | DW'(r);
    assign n_arr[g]   = r[W-1];
    assign z_arr[g]   = ~|r;
  end

  always_comb begin
    sidx  = size_index(size_sel);
    res   = res_arr[sidx];
    nxt.x = x_arr[sidx];
    nxt.n = n_arr[sidx];
    nxt.z = z_arr[sidx];
    nxt.v = v_arr[sidx];
    nxt.c = c_arr[sidx];
  end

  srx_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (upd_valid),
    .d     (nxt),
    .q     (cur)
  );

  assign flg_x = cur.x;
  assign flg_n = cur.n;
  assign flg_z = cur.z;
  assign flg_v = cur.v;
  assign flg_c = cur.c;

  logic is_shift, is_rox, is_rot;
  assign is_shift = ~op_sel[2];
  assign is_rox   = op_sel[2:1] == 2'b10;
  assign is_rot   = op_sel[2:1] == 2'b11;

  AST_ZERO_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && is_shift && amount == '0 |=>
      flg_x == $past(x_cur) && !flg_v && !flg_c); // R4

  AST_ROX_ZERO_TAKES_X: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && is_rox && amount == '0 |=>
      flg_c == $past(x_cur) && flg_x == $past(x_cur)); // R6

  AST_ROT_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && is_rot |=> flg_x == $past(x_cur)); // R5

  AST_ONLY_ASL_OVERFLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && op_t != OP_ASL |=> !flg_v); // R3

  AST_SHIFT_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && is_shift && amount != '0 |=> flg_x == flg_c); // R7

endmodule

// File: tb/srx_unit_tb.sv
`timescale 1ns/1ps
module srx_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [31:0] opnd = '0;
  logic [5:0]  amount = '0;
  logic [1:0]  size_sel = '0;
  logic [2:0]  op_sel = '0;
  logic        x_cur = 1'b0;
  logic [31:0] res;
  logic        flg_x, flg_n, flg_z, flg_v, flg_c;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  srx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .opnd(opnd),
    .amount(amount), .size_sel(size_sel), .op_sel(op_sel), .x_cur(x_cur),
    .res(res), .flg_x(flg_x), .flg_n(flg_n), .flg_z(flg_z),
    .flg_v(flg_v), .flg_c(flg_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%0d size=%0d cnt=%0d x=%0b opnd=%h)",
               tag, act, exp, op_sel, size_sel, amount, x_cur, opnd);
    end
  endtask

  // Bit-at-a-time reference; flags packed as {x,n,z,v,c}
  task automatic model(input logic [31:0] a_in, input int cnt, input int w,
                       input int op, input bit xi,
                       output logic [31:0] r_out, output logic [4:0] fl);
    logic [31:0] m, a;
    bit x, c, v, o, msb_prev;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    a = a_in & m;
    x = xi; c = 0; v = 0;
    for (int i = 0; i < cnt; i++) begin
      msb_prev = a[w-1];
      case (op)
        1, 3: begin o = a[w-1]; a = (a << 1) & m; c = o; x = o;
                    if (op == 1 && a[w-1] != msb_prev) v = 1; end
        2:    begin o = a[0]; a = a >> 1; c = o; x = o; end
        0:    begin o = a[0]; a = (a >> 1) | (a[w-1] ? (32'h1 << (w-1)) : 0);
                    c = o; x = o; end
        7:    begin o = a[w-1]; a = ((a << 1) & m) | 32'(o); c = o; end
        6:    begin o = a[0]; a = (a >> 1) | (o ? (32'h1 << (w-1)) : 0); c = o; end
        5:    begin o = a[w-1]; a = ((a << 1) & m) | 32'(x); x = o; c = o; end
        default: begin o = a[0]; a = (a >> 1) | (x ? (32'h1 << (w-1)) : 0);
                    x = o; c = o; end
      endcase
    end
    if (cnt == 0 && (op == 4 || op == 5)) c = x;
    r_out = (a_in & ~m) | a;
    fl = {x, a[w-1], (a == 0), v, c};
  endtask

  function automatic string tag_of(input int op, input int cnt);
    if (op < 4 && cnt == 0) return "R4";
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R1";
      4, 5: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic run_vec(input logic [31:0] a, input int cnt, input int sz,
                         input int op, input bit xi, input string extra);
    logic [31:0] er, m;
    logic [4:0]  ef, af;
    int w;
    string t;
    w = (sz == 3) ? 32 : (8 << sz);
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    opnd = a; amount = 6'(cnt); size_sel = 2'(sz); op_sel = 3'(op);
    x_cur = xi; upd_valid = 1'b1;
    model(a, cnt, w, op, xi, er, ef);
    @(negedge clk);
    t = {tag_of(op, cnt), extra};
    af = {flg_x, flg_n, flg_z, flg_v, flg_c};
    chk(res == er, {t, " result"}, res, er);
    chk(af == ef, {t, " flags xnzvc"}, 32'(af), 32'(ef));
    chk(af[3:2] == ef[3:2], "R8 n/z", 32'(af[3:2]), 32'(ef[3:2]));
    chk((res & ~m) == (a & ~m), "R8 upper bits", res & ~m, a & ~m);
    if (op < 4 && cnt != 0)
      chk(flg_x == flg_c, "R7 x equals c", 32'(flg_x), 32'(flg_c));
  endtask

  initial begin
    logic [31:0] pats [6];
    logic [4:0]  held;
    pats[0] = 32'hA5C3_0F81; pats[1] = 32'h1234_4000; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000; pats[4] = 32'h7FFF_FF7F; pats[5] = 32'h8001_8001;

    repeat (3) @(negedge clk);
    chk({flg_x, flg_n, flg_z, flg_v, flg_c} == 5'b0, "R9 reset flags",
        32'({flg_x, flg_n, flg_z, flg_v, flg_c}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({flg_x, flg_n, flg_z, flg_v, flg_c} == 5'b0, "R9 idle after reset",
        32'({flg_x, flg_n, flg_z, flg_v, flg_c}), 32'h0);

    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int p = 0; p < 6; p++)
          for (int xi = 0; xi < 2; xi++)
            for (int cnt = 0; cnt < 64; cnt++)
              run_vec(pats[p], cnt, sz, op, bit'(xi), "");

    // Size code 3 behaves as long
    for (int op = 0; op < 8; op++)
      for (int cnt = 0; cnt < 64; cnt += 7)
        run_vec(32'hC001_0F0E, cnt, 3, op, 1'b1, " R10");

    // Strobe low: flags must hold while inputs change
    run_vec(32'h0000_0081, 1, 0, 1, 1'b0, "");
    held = {flg_x, flg_n, flg_z, flg_v, flg_c};
    for (int i = 0; i < 4; i++) begin
      upd_valid = 1'b0;
      opnd = 32'h0000_0000; amount = 6'(i); op_sel = 3'd5; x_cur = 1'b1;
      size_sel = 2'(i % 3);
      @(negedge clk);
      chk({flg_x, flg_n, flg_z, flg_v, flg_c} == held, "R9 hold without strobe",
          32'({flg_x, flg_n, flg_z, flg_v, flg_c}), 32'(held));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule